// File: doc/BRIEF.md
# Eager-Hop Liveness Classifier for a Mesh Router Input

This block sits on one input of a two-dimensional mesh router in which some input-to-output pairs are wired through ahead of arbitration, so a flit can be pushed one hop onward before anyone has checked whether that hop helps it. For every head flit the block looks at the destination coordinates, the router's own coordinates, the direction of the hop that brought the flit here, and whether that hop was an eager one. It decides whether the flit is still useful or is a dead copy. It also computes the dimension-ordered output the flit needs, and whether the flit has to be written into the input FIFO for normal switching.

The liveness test is relaxed. An eager hop is accepted as soon as it did not move the flit away from its destination on the axis it travelled. A hop that moved the flit away is dead, unless the flit had been steered by the adaptive mode or has already reached this router. A live flit is still queued for normal switching unless the pre-wired output of this input already leads along its XY route. A flit can therefore leave this router twice, which the network tolerates. Body flits reuse the verdict taken for their head up to and including the tail. The verdict appears one cycle after the flit is presented.

Top module: `flit_classifier`

## Requirements
- R1: During and right after reset, out_valid, out_enq, out_dead and out_port are all 0.
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high.
- R3: Route codes are local=0, north=1, east=2, south=3, west=4. North means rising Y and east means rising X. A head goes east if dst_x > my_x and west if dst_x < my_x; otherwise it goes north if dst_y > my_y and south if dst_y < my_y.
- R4: A head whose destination equals (my_x, my_y) gets out_port 0 and is never dead.
- R5: A head with in_eager low is never dead.
- R6: An eager head stays live when its hop direction (in_hop_dir, same codes as R3) did not move it away on that axis. The conditions are: east with dst_x >= my_x, west with dst_x <= my_x, north with dst_y >= my_y, south with dst_y <= my_y.
- R7: An eager head whose hop moved it away, or whose hop code is 0, 5, 6 or 7, is dead, unless R4 or R8 applies.
- R8: A head with in_adaptive high is never dead.
- R9: A dead flit has out_enq low.
- R10: A live head has out_enq low only when pref_en is high and pref_out equals its route; otherwise out_enq is high.
- R11: Body flits up to and including the tail repeat the head's out_port, out_enq and out_dead. Their own coordinates, pref_en, pref_out and idle cycles between flits have no effect on this.
- R12: A body flit with no open packet (after a tail, or after reset) is dropped: out_enq 0, out_dead 1, out_port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_x | input | 4 | X coordinate of this router |
| my_y | input | 4 | Y coordinate of this router |
| in_valid | input | 1 | A flit is present this cycle |
| in_head | input | 1 | The flit is a head flit |
| in_tail | input | 1 | The flit is the last of its packet |
| in_dst_x | input | 4 | Destination X (read on heads only) |
| in_dst_y | input | 4 | Destination Y (read on heads only) |
| in_eager | input | 1 | The flit arrived over a pre-wired hop |
| in_hop_dir | input | 3 | Direction of travel of that hop, R3 codes |
| in_adaptive | input | 1 | The flit was steered by the adaptive mode |
| pref_en | input | 1 | This input has a pre-wired output |
| pref_out | input | 3 | Code of the pre-wired output |
| out_valid | output | 1 | Verdict is valid |
| out_port | output | 3 | Output the flit needs |
| out_enq | output | 1 | Write the flit into the input FIFO |
| out_dead | output | 1 | The flit is a dead copy and is discarded |

## Verification
The packet-close path and the verdict path can act in the same cycle. A single flit with head and tail both set has its verdict computed and its packet closed at one edge. The bench provokes this by following such a flit directly with a body flit. It judges the result by whether that body flit comes out dropped instead of inheriting the head's route. A long packet whose tail comes straight after a head-only flit is handled the same way, and so is reconfiguration of the pre-wired output while a packet is open. In the latter case the bench expects the held verdict to win.

// File: rtl/flitcls_pkg.sv
package flitcls_pkg;
    localparam int COORD_W = 4;
    localparam int PORT_W  = 3;

    typedef logic [COORD_W-1:0] coord_t;

    typedef enum logic [PORT_W-1:0] {
        PORT_LOCAL = 3'd0,
        PORT_NORTH = 3'd1,
        PORT_EAST  = 3'd2,
        PORT_SOUTH = 3'd3,
        PORT_WEST  = 3'd4
    } port_e;

    typedef struct packed {
        port_e port;
        logic  enq;
        logic  dead;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE   = '{port: PORT_LOCAL, enq: 1'b0, dead: 1'b0};
    localparam verdict_t VERDICT_ORPHAN = '{port: PORT_LOCAL, enq: 1'b0, dead: 1'b1};

    // Dimension-ordered choice: resolve X before Y.
    function automatic port_e xy_pick(coord_t mx, coord_t my, coord_t dx, coord_t dy);
        if (dx > mx)      return PORT_EAST;
        else if (dx < mx) return PORT_WEST;
        else if (dy > my) return PORT_NORTH;
        else if (dy < my) return PORT_SOUTH;
        else              return PORT_LOCAL;
    endfunction

    // True when a hop in direction dir did not carry the flit away on its axis.
    function automatic logic hop_useful(logic [PORT_W-1:0] dir, coord_t mx, coord_t my,
                                        coord_t dx, coord_t dy);
        case (dir)
            PORT_EAST:  return dx >= mx;
            PORT_WEST:  return dx <= mx;
            PORT_NORTH: return dy >= my;
            PORT_SOUTH: return dy <= my;
            default:    return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/fc_route.sv
module fc_route
    import flitcls_pkg::*;
(
    input  coord_t my_x,
    input  coord_t my_y,
    input  coord_t dst_x,
    input  coord_t dst_y,
    output port_e  route,
    output logic   arrived
);
    always_comb begin
        route   = xy_pick(my_x, my_y, dst_x, dst_y);
        arrived = (dst_x == my_x) && (dst_y == my_y);
    end
endmodule

// File: rtl/fc_judge.sv
module fc_judge
    import flitcls_pkg::*;
(
    input  coord_t             my_x,
    input  coord_t             my_y,
    input  coord_t             dst_x,
    input  coord_t             dst_y,
    input  logic               eager,
    input  logic [PORT_W-1:0]  hop_dir,
    input  logic               adaptive,
    input  logic               pref_en,
    input  logic [PORT_W-1:0]  pref_out,
    input  port_e              route,
    input  logic               arrived,
    output verdict_t           verdict
);
    logic useful;
    logic is_dead;
    logic covered;

    always_comb begin
        useful  = hop_useful(hop_dir, my_x, my_y, dst_x, dst_y);
        is_dead = eager && !adaptive && !arrived && !useful;
        // The pre-wired output already carries the flit where XY wants it.
        covered = pref_en && (pref_out == route);
        verdict.port = route;
        verdict.dead = is_dead;
        verdict.enq  = !is_dead && !covered;
    end
endmodule

// File: rtl/fc_hold.sv
module fc_hold
    import flitcls_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  logic     in_head,
    input  logic     in_tail,
    input  verdict_t fresh,
    output logic     out_valid,
    output verdict_t out_verdict
);
    verdict_t held;
    verdict_t pick;

    always_comb pick = in_head ? fresh : held;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_verdict <= VERDICT_IDLE;
            held        <= VERDICT_ORPHAN;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_verdict <= pick;
                if (in_tail)      held <= VERDICT_ORPHAN;
                else if (in_head) held <= fresh;
            end
        end
    end
endmodule

// File: rtl/flit_classifier.sv
module flit_classifier
    import flitcls_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [COORD_W-1:0]  my_x,
    input  logic [COORD_W-1:0]  my_y,
    input  logic                in_valid,
    input  logic                in_head,
    input  logic                in_tail,
    input  logic [COORD_W-1:0]  in_dst_x,
    input  logic [COORD_W-1:0]  in_dst_y,
    input  logic                in_eager,
    input  logic [PORT_W-1:0]   in_hop_dir,
    input  logic                in_adaptive,
    input  logic                pref_en,
    input  logic [PORT_W-1:0]   pref_out,
    output logic                out_valid,
    output logic [PORT_W-1:0]   out_port,
    output logic                out_enq,
    output logic                out_dead
);
    port_e    route;
    logic     arrived;
    verdict_t fresh;
    verdict_t held_out;
    logic     vld_q;

    fc_route u_route (
        .my_x    (my_x),
        .my_y    (my_y),
        .dst_x   (in_dst_x),
        .dst_y   (in_dst_y),
        .route   (route),
        .arrived (arrived)
    );

    fc_judge u_judge (
        .my_x     (my_x),
        .my_y     (my_y),
        .dst_x    (in_dst_x),
        .dst_y    (in_dst_y),
        .eager    (in_eager),
        .hop_dir  (in_hop_dir),
        .adaptive (in_adaptive),
        .pref_en  (pref_en),
        .pref_out (pref_out),
        .route    (route),
        .arrived  (arrived),
        .verdict  (fresh)
    );

    fc_hold u_hold (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_head     (in_head),
        .in_tail     (in_tail),
        .fresh       (fresh),
        .out_valid   (vld_q),
        .out_verdict (held_out)
    );

    always_comb begin
        out_valid = vld_q;
        out_port  = vld_q ? held_out.port : PORT_LOCAL;
        out_enq   = vld_q && held_out.enq;
        out_dead  = vld_q && held_out.dead;
    end
endmodule

// File: rtl/fc_checker.sv
module fc_checker
    import flitcls_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [COORD_W-1:0]  my_x,
    input logic [COORD_W-1:0]  my_y,
    input logic                in_valid,
    input logic                in_head,
    input logic                in_tail,
    input logic [COORD_W-1:0]  in_dst_x,
    input logic [COORD_W-1:0]  in_dst_y,
    input logic                in_eager,
    input logic [PORT_W-1:0]   in_hop_dir,
    input logic                in_adaptive,
    input logic                pref_en,
    input logic [PORT_W-1:0]   pref_out,
    input logic                out_valid,
    input logic [PORT_W-1:0]   out_port,
    input logic                out_enq,
    input logic                out_dead
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_home_is_local_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_head && in_dst_x == my_x && in_dst_y == my_y)
        |=> (out_port == 3'd0 && !out_dead));

    assert_plain_never_dead_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_head && !in_eager) |=> !out_dead);

    assert_east_gain_live_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_head && in_eager && in_hop_dir == 3'd2 && in_dst_x >= my_x)
        |=> !out_dead);

    assert_adaptive_live_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_head && in_adaptive) |=> !out_dead);

    assert_dead_not_queued_R9: assert property (@(posedge clk) disable iff (rst)
        out_dead |-> !out_enq);

    assert_body_inherits_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_head && !in_tail) ##1 (in_valid && !in_head)
        |=> ($stable(out_port) && $stable(out_enq) && $stable(out_dead)));
endmodule

bind flit_classifier fc_checker u_fc_checker (.*);

// File: tb/tb_flit_classifier.sv
module tb_flit_classifier;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] my_x, my_y, in_dst_x, in_dst_y;
    logic       in_valid, in_head, in_tail, in_eager, in_adaptive, pref_en;
    logic [2:0] in_hop_dir, pref_out;
    logic       out_valid, out_enq, out_dead;
    logic [2:0] out_port;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    flit_classifier dut (
        .clk(clk), .rst(rst), .my_x(my_x), .my_y(my_y),
        .in_valid(in_valid), .in_head(in_head), .in_tail(in_tail),
        .in_dst_x(in_dst_x), .in_dst_y(in_dst_y), .in_eager(in_eager),
        .in_hop_dir(in_hop_dir), .in_adaptive(in_adaptive),
        .pref_en(pref_en), .pref_out(pref_out),
        .out_valid(out_valid), .out_port(out_port),
        .out_enq(out_enq), .out_dead(out_dead)
    );

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Present a flit at a falling edge; outputs are read at the next falling edge.
    task automatic drive(bit hd, bit tl, bit eg, int hop, bit ad, int dx, int dy,
                         bit pe, int po);
        in_valid = 1'b1; in_head = hd; in_tail = tl; in_eager = eg;
        in_hop_dir = 3'(hop); in_adaptive = ad; in_dst_x = 4'(dx); in_dst_y = 4'(dy);
        pref_en = pe; pref_out = 3'(po);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(string tag, int port, bit enq, bit dead);
        chk({tag, " valid"}, out_valid, 1);
        chk({tag, " port"},  out_port, port);
        chk({tag, " enq"},   out_enq, enq);
        chk({tag, " dead"},  out_dead, dead);
    endtask

    task automatic idle_cycle();
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2 idle gives no valid", out_valid, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_head = 0; in_tail = 0; in_eager = 0;
        in_hop_dir = 0; in_adaptive = 0; in_dst_x = 0; in_dst_y = 0;
        pref_en = 0; pref_out = 0; my_x = 4'd5; my_y = 4'd5;
        repeat (3) @(negedge clk);
        chk("R1 valid", out_valid, 0); chk("R1 enq", out_enq, 0);
        chk("R1 dead", out_dead, 0);   chk("R1 port", out_port, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", out_valid, 0);
    endtask

    task automatic t_xy();
        drive(1,1,0,0,0, 9,2, 0,0); expect_out("R3 east R5", 2, 1, 0);
        drive(1,1,0,0,0, 1,9, 0,0); expect_out("R3 west", 4, 1, 0);
        drive(1,1,0,0,0, 5,9, 0,0); expect_out("R3 north", 1, 1, 0);
        drive(1,1,0,0,0, 5,0, 0,0); expect_out("R3 south", 3, 1, 0);
        drive(1,1,0,0,0, 5,5, 0,0); expect_out("R4 home", 0, 1, 0);
        idle_cycle();
    endtask

    task automatic t_eager();
        drive(1,1,1,2,0, 9,5, 0,0); expect_out("R6 east toward", 2, 1, 0);
        drive(1,1,1,2,0, 2,9, 0,0); expect_out("R7 east away", 4, 0, 1);
        drive(1,1,1,1,0, 2,9, 0,0); expect_out("R6 north toward", 4, 1, 0);
        drive(1,1,1,3,0, 2,9, 0,0); expect_out("R7 south away", 4, 0, 1);
        drive(1,1,1,4,0, 2,9, 0,0); expect_out("R6 west toward", 4, 1, 0);
        drive(1,1,1,3,0, 9,5, 0,0); expect_out("R6 south equal y", 2, 1, 0);
        drive(1,1,1,0,0, 9,9, 0,0); expect_out("R7 bad hop code", 2, 0, 1);
        drive(1,1,1,6,0, 9,9, 0,0); expect_out("R7 hop code 6", 2, 0, 1);
        drive(1,1,1,0,0, 5,5, 0,0); expect_out("R4 home overrides", 0, 1, 0);
        drive(1,1,1,2,1, 2,9, 0,0); expect_out("R8 adaptive live", 4, 1, 0);
    endtask

    task automatic t_pref();
        drive(1,1,0,0,0, 9,2, 1,2); expect_out("R10 covered", 2, 0, 0);
        drive(1,1,0,0,0, 9,2, 1,3); expect_out("R10 other pref", 2, 1, 0);
        drive(1,1,0,0,0, 9,2, 0,2); expect_out("R10 pref off", 2, 1, 0);
        drive(1,1,1,2,0, 2,9, 1,4); expect_out("R9 dead not queued", 4, 0, 1);
    endtask

    task automatic t_packet();
        drive(1,0,0,0,0, 9,2, 0,0); expect_out("R11 head", 2, 1, 0);
        drive(0,0,0,0,0, 0,0, 1,2); expect_out("R11 body ignores pref", 2, 1, 0);
        idle_cycle();
        drive(0,1,1,3,0, 5,5, 0,0); expect_out("R11 tail", 2, 1, 0);
        drive(0,0,0,0,0, 9,2, 0,0); expect_out("R12 after tail", 0, 0, 1);
        drive(1,0,1,2,0, 2,9, 0,0); expect_out("R11 dead head", 4, 0, 1);
        drive(0,1,0,0,0, 9,9, 0,0); expect_out("R11 dead tail", 4, 0, 1);
        drive(1,1,0,0,0, 5,9, 0,0); expect_out("R12 single flit", 1, 1, 0);
        drive(0,0,0,0,0, 5,9, 0,0); expect_out("R12 body after single", 0, 0, 1);
        idle_cycle();
    endtask

    task automatic t_reset_orphan();
        drive(1,0,0,0,0, 9,2, 0,0); expect_out("R11 head before reset", 2, 1, 0);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R1 mid-run reset", out_valid, 0);
        drive(0,0,0,0,0, 9,2, 0,0); expect_out("R12 body after reset", 0, 0, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_xy();
        t_eager();
        t_pref();
        t_packet();
        t_reset_orphan();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule